// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the settings of a clock synthesizer: a 9-bit feedback multiplier M, a 2-bit output divider code N and a 2-bit test-select code. Two write paths reach these registers. The parallel path is controlled by an active-low strobe. While the strobe is low, the registers follow the parallel pins. When the strobe rises, the last value is frozen. The serial path uses its own clock, data and load pins. A 14-bit frame is shifted in, then moved into the registers when the serial load pin goes high. While the load pin stays high, each serial clock edge moves the freshly shifted contents into the registers at once.

All pins are treated as asynchronous. They are brought into the system clock domain through a synchronizer, and every register runs on that clock. A test pin shows one of four sources, picked by the test-select code. It is forced low while the parallel path is in control. A flag reports when the held M value lies outside the lockable window of 25 to 31.

Top module: `cfg_loader`

## Requirements
- R1: While `pload_n` is low, `cfg_m` and `cfg_n` follow `par_m` and `par_n`, within a few system clock cycles.
- R2: After `pload_n` rises, `cfg_m` and `cfg_n` keep their value when the parallel pins change.
- R3: The serial frame is 14 bits, sent first bit first: T1, T0, a spare slot, N1, N0, M8 down to M0. A rising edge on `ser_load` copies the shifted frame into the registers: bits 8..0 go to `cfg_m`, bits 10..9 go to `cfg_n` and bits 13..12 go to `cfg_t`, with bit 13 being the first bit sent.
- R4: The spare slot (frame bit 11) has no effect on any output register.
- R5: Shifting with `ser_load` low leaves `cfg_m`, `cfg_n` and `cfg_t` unchanged.
- R6: While `ser_load` stays high, each rising `ser_clk` edge shifts in one bit and copies the new frame contents into the registers.
- R7: Serial clock edges that occur while `pload_n` is low do not alter the shift register.
- R8: When `pload_n` falls, the parallel pins take the registers over again, even after a serial load.
- R9: When `pload_n` is high, `test_out` follows `cfg_t`. Code 00 gives 0, code 01 gives `ser_data`, code 10 gives `fb_div_in` and code 11 gives `syn_clk_in`.
- R10: `test_out` is 0 while `pload_n` is low, whatever the value of `cfg_t`.
- R11: `m_range_err` is 1 exactly when `cfg_m` is below 25 or above 31.
- R12: Reset clears the shift register and `cfg_t`, and loads `cfg_m` and `cfg_n` from the parallel pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_m | input | 9 | Parallel multiplier value |
| par_n | input | 2 | Parallel output divider code |
| pload_n | input | 1 | Parallel strobe, active low (transparent while low) |
| ser_clk | input | 1 | Serial shift clock (rising edge active) |
| ser_data | input | 1 | Serial frame bit |
| ser_load | input | 1 | Serial transfer strobe |
| fb_div_in | input | 1 | Feedback divider output, a source for the test pin |
| syn_clk_in | input | 1 | Synthesized clock, a source for the test pin |
| cfg_m | output | 9 | Held multiplier value |
| cfg_n | output | 2 | Held output divider code |
| cfg_t | output | 2 | Held test-select code |
| test_out | output | 1 | Selected test source |
| m_range_err | output | 1 | Held M is outside 25..31 |

## Verification
The assertions assume that the serial clock, serial data and both strobes each stay at one level for longer than the synchronizer depth. They also assume that `ser_data` is steady on both sides of every `ser_clk` edge, so that edges detected after synchronization line up with settled data. The bench holds every such pin for at least four system cycles before and after each edge. It changes the parallel pins only while the matching strobe is steady, and it keeps `ser_clk` low across reset.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    typedef enum logic [1:0] {
        TSEL_LOW    = 2'b00,
        TSEL_SDATA  = 2'b01,
        TSEL_FBDIV  = 2'b10,
        TSEL_OUTCLK = 2'b11
    } tsel_e;
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        if (!rst_n) begin
            chain_d = '0;
        end else begin
            chain_d[0] = din;
            for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) chain_q <= chain_d;

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
    parameter int M_W = 9,
    parameter int N_W = 2,
    parameter int T_W = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           din,
    output logic [M_W-1:0] m_nx,
    output logic [N_W-1:0] n_nx,
    output logic [T_W-1:0] t_nx
);
    localparam int N_LSB   = M_W;
    localparam int SPARE   = M_W + N_W;
    localparam int T_LSB   = SPARE + 1;
    localparam int FRAME_W = T_LSB + T_W;

    logic [FRAME_W-1:0] img_d, img_q;

    always_comb begin
        img_d = img_q;
        if (!rst_n)        img_d = '0;
        else if (shift_en) img_d = {img_q[FRAME_W-2:0], din};
    end

    always_ff @(posedge clk) img_q <= img_d;

    assign m_nx = img_d[M_W-1:0];
    assign n_nx = img_d[N_LSB +: N_W];
    assign t_nx = img_d[T_LSB +: T_W];

    // R3
    shift_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> img_q[0] == $past(din));

    // R7
    img_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(img_q));
endmodule

// File: rtl/cfgld_test_mux.sv
module cfgld_test_mux
    import cfgld_pkg::*;
(
    input  tsel_e sel,
    input  logic  force_low,
    input  logic  sdata,
    input  logic  fbdiv,
    input  logic  outclk,
    output logic  y
);
    always_comb begin
        unique case (sel)
            TSEL_LOW:    y = 1'b0;
            TSEL_SDATA:  y = sdata;
            TSEL_FBDIV:  y = fbdiv;
            TSEL_OUTCLK: y = outclk;
            default:     y = 1'b0;
        endcase
        if (force_low) y = 1'b0;
    end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfgld_pkg::*;
#(
    parameter int M_W         = 9,
    parameter int N_W         = 2,
    parameter int T_W         = 2,
    parameter int SYNC_STAGES = 2,
    parameter int M_LOCK_MIN  = 25,
    parameter int M_LOCK_MAX  = 31
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           pload_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic           fb_div_in,
    input  logic           syn_clk_in,
    output logic [M_W-1:0] cfg_m,
    output logic [N_W-1:0] cfg_n,
    output logic [T_W-1:0] cfg_t,
    output logic           test_out,
    output logic           m_range_err
);
    localparam int PL = 0, SCK = 1, SDA = 2, SLD = 3;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
        logic [T_W-1:0] t;
        logic           err;
        logic           sck_prev;
        logic           sld_prev;
    } state_t;

    state_t st_d, st_q;
    logic [3:0] pins_s;
    logic pl_lvl, sck_rise, sld_lvl, sld_rise, serial_mode, xfer;
    logic [M_W-1:0] sh_m;
    logic [N_W-1:0] sh_n;
    logic [T_W-1:0] sh_t;

    cfgld_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_load, ser_data, ser_clk, pload_n}),
        .dout (pins_s)
    );

    assign pl_lvl      = pins_s[PL];
    assign sld_lvl     = pins_s[SLD];
    assign sck_rise    = pins_s[SCK] & ~st_q.sck_prev;
    assign sld_rise    = sld_lvl & ~st_q.sld_prev;
    assign serial_mode = pl_lvl;
    assign xfer        = serial_mode & (sld_rise | (sld_lvl & sck_rise));

    cfgld_shifter #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(serial_mode & sck_rise),
        .din     (pins_s[SDA]),
        .m_nx    (sh_m),
        .n_nx    (sh_n),
        .t_nx    (sh_t)
    );

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = pins_s[SCK];
        st_d.sld_prev = sld_lvl;
        if (!rst_n) begin
            st_d.m        = par_m;
            st_d.n        = par_n;
            st_d.t        = '0;
            st_d.sck_prev = 1'b0;
            st_d.sld_prev = 1'b0;
        end else if (!pl_lvl) begin
            st_d.m = par_m;
            st_d.n = par_n;
        end else if (xfer) begin
            st_d.m = sh_m;
            st_d.n = sh_n;
            st_d.t = sh_t;
        end
        st_d.err = (st_d.m < M_W'(M_LOCK_MIN)) || (st_d.m > M_W'(M_LOCK_MAX));
    end

    always_ff @(posedge clk) st_q <= st_d;

    cfgld_test_mux u_tmux (
        .sel      (tsel_e'(st_q.t[1:0])),
        .force_low(~pl_lvl),
        .sdata    (ser_data),
        .fbdiv    (fb_div_in),
        .outclk   (syn_clk_in),
        .y        (test_out)
    );

    assign cfg_m       = st_q.m;
    assign cfg_n       = st_q.n;
    assign cfg_t       = st_q.t;
    assign m_range_err = st_q.err;

    // R10
    test_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_lvl |-> !test_out);

    // R11
    lock_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_range_err == ((cfg_m < M_W'(M_LOCK_MIN)) || (cfg_m > M_W'(M_LOCK_MAX))));

    // R2 R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_lvl && !xfer) |=> ($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t)));

    // R12
    reset_t_chk: assert property (@(posedge clk)
        !rst_n |=> cfg_t == '0);
endmodule

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [8:0] par_m = 9'd27;
    logic [1:0] par_n = 2'd2;
    logic pload_n = 1'b1, ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic fb_div_in = 1'b0, syn_clk_in = 1'b0;
    logic [8:0] cfg_m;
    logic [1:0] cfg_n, cfg_t;
    logic test_out, m_range_err;

    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    cfg_loader u0 (
        .clk(clk), .rst_n(rst_n), .par_m(par_m), .par_n(par_n), .pload_n(pload_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
        .fb_div_in(fb_div_in), .syn_clk_in(syn_clk_in),
        .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t),
        .test_out(test_out), .m_range_err(m_range_err)
    );

    // frame: {T1,T0, spare, N1,N0, M8..M0}
    localparam logic [13:0] VEC [6] = '{
        {2'b00, 1'b0, 2'b01, 9'd25},
        {2'b01, 1'b1, 2'b10, 9'd31},
        {2'b10, 1'b0, 2'b11, 9'd24},
        {2'b11, 1'b1, 2'b00, 9'd32},
        {2'b01, 1'b0, 2'b01, 9'd28},
        {2'b10, 1'b1, 2'b10, 9'h1FF}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic range_bad(input logic [8:0] m);
        return (m < 9'd25) || (m > 9'd31);
    endfunction

    task automatic shift_bit(input logic b);
        ser_data = b;
        wait_cyc(4);
        ser_clk = 1'b1;
        wait_cyc(4);
        ser_clk = 1'b0;
        wait_cyc(2);
    endtask

    task automatic shift_frame(input logic [13:0] f);
        for (int i = 13; i >= 0; i--) shift_bit(f[i]);
    endtask

    task automatic strobe();
        ser_load = 1'b1;
        wait_cyc(6);
        ser_load = 1'b0;
        wait_cyc(6);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        wait_cyc(150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

    initial begin
        logic [13:0] sr;
        logic [8:0] pm_before;
        logic exp_t;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(8);
        // R12: pins loaded, test bits cleared
        check("R12 m", cfg_m, 27);
        check("R12 n", cfg_n, 2);
        check("R12 t", cfg_t, 0);
        check("R11 err in range", m_range_err, 0);
        strobe();
        // R12: shift register was cleared
        check("R12 sr m", cfg_m, 0);
        check("R12 sr n", cfg_n, 0);
        check("R11 err low M", m_range_err, 1);

        // R1 transparent parallel
        pload_n = 1'b0;
        par_m = 9'd30; par_n = 2'd1;
        wait_cyc(8);
        check("R1 m", cfg_m, 30);
        check("R1 n", cfg_n, 1);
        par_m = 9'd100; par_n = 2'd3;
        wait_cyc(8);
        check("R1 m follow", cfg_m, 100);
        check("R11 err high M", m_range_err, 1);
        pload_n = 1'b1;
        wait_cyc(8);
        par_m = 9'd26; par_n = 2'd0;
        wait_cyc(8);
        // R2 held after strobe rise
        check("R2 m", cfg_m, 100);
        check("R2 n", cfg_n, 3);

        // vector walk
        for (int v = 0; v < 6; v++) begin
            pm_before = cfg_m;
            shift_frame(VEC[v]);
            check("R5 hold m", cfg_m, pm_before);
            strobe();
            check("R3 m", cfg_m, VEC[v][8:0]);
            check("R3 n", cfg_n, VEC[v][10:9]);
            check("R3 t", cfg_t, VEC[v][13:12]);
            check("R11 err", m_range_err, range_bad(VEC[v][8:0]));
            for (int p = 0; p < 3; p++) begin
                ser_data   = (p == 0);
                fb_div_in  = (p == 1);
                syn_clk_in = (p == 2);
                #1;
                case (VEC[v][13:12])
                    2'b00: exp_t = 1'b0;
                    2'b01: exp_t = ser_data;
                    2'b10: exp_t = fb_div_in;
                    default: exp_t = syn_clk_in;
                endcase
                check("R9 test_out", test_out, exp_t);
            end
            ser_data = 1'b0; fb_div_in = 1'b0; syn_clk_in = 1'b0;
        end

        // R4 spare slot ignored
        sr = {2'b00, 1'b1, 2'b11, 9'd29};
        shift_frame(sr);
        strobe();
        check("R4 m", cfg_m, 29);
        check("R4 n", cfg_n, 3);
        check("R4 t", cfg_t, 0);

        // R6 load held high: each clock transfers
        ser_load = 1'b1;
        wait_cyc(8);
        for (int k = 0; k < 3; k++) begin
            logic b;
            b = (k != 1);
            shift_bit(b);
            sr = {sr[12:0], b};
            check("R6 m", cfg_m, sr[8:0]);
            check("R6 t", cfg_t, sr[13:12]);
        end
        ser_load = 1'b0;
        wait_cyc(6);

        // R10 / R8
        sr = {2'b11, 1'b0, 2'b10, 9'd26};
        shift_frame(sr);
        strobe();
        syn_clk_in = 1'b1;
        #1;
        check("R9 outclk", test_out, 1);
        par_m = 9'd20; par_n = 2'd1;
        pload_n = 1'b0;
        wait_cyc(8);
        check("R10 forced low", test_out, 0);
        check("R8 m", cfg_m, 20);
        check("R8 n", cfg_n, 1);
        syn_clk_in = 1'b0;

        // R7 clocks in parallel mode ignored
        shift_frame(14'h3FFF);
        pload_n = 1'b1;
        wait_cyc(8);
        strobe();
        check("R7 m", cfg_m, sr[8:0]);
        check("R7 n", cfg_n, sr[10:9]);
        check("R7 t", cfg_t, sr[13:12]);

        done = 1'b1;
        report();
    end
endmodule